// File: doc/BRIEF.md
# Sum-and-Stream Serializer

This block adds two unsigned operands of a parameterized width and sends the result out on a single wire, one bit per clock. A load strobe captures the truncated sum into a shift register. The carry out of the top bit goes into a separate flip-flop at the same time. On every later clock without a load, the register moves one place toward the output and takes in a zero at its top end. The serial line therefore carries the sum least significant bit first and then stays low.

A synchronous clear has priority over everything else. It empties both the data register and the carry flip-flop. A load has priority over shifting. A new load in the middle of a stream abandons the remaining bits and starts the new result at once. The stored carry is visible on its own output pin.

Top module: `ssum_serializer`

## Requirements
- R1: With `clr_i` high at a rising edge, `ser_o` and `carry_o` are both 0 after that edge.
- R2: A clear outranks a load. With `clr_i` and `load_i` both high at an edge, both outputs are 0 afterwards, whatever the operands are.
- R3: With `clr_i` low and `load_i` high at an edge, the register takes `(opa_i + opb_i) mod 2**WIDTH`. Bit 0 of that value appears on `ser_o` right after that edge.
- R4: On a load, `carry_o` becomes bit WIDTH of the unsigned sum `opa_i + opb_i`. It keeps that value through every following shift edge.
- R5: After a load, each edge with `clr_i` and `load_i` both low shifts the register toward bit 0. After k such edges, `ser_o` shows bit k of the loaded sum, for k from 0 to WIDTH-1.
- R6: Shifting fills the top of the register with zeros. Once WIDTH shift edges have followed a load, `ser_o` stays 0 until the next load.
- R7: A load that arrives while a stream is partly sent drops the bits not yet sent. It restarts the stream with bit 0 of the new sum right after that edge.
- R8: A clear that arrives while a stream is partly sent ends the stream. `ser_o` then stays 0 through the following shift edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| clr_i | input | 1 | Synchronous clear; highest priority |
| load_i | input | 1 | Captures the sum of the operands |
| opa_i | input | WIDTH | First operand, unsigned |
| opb_i | input | WIDTH | Second operand, unsigned |
| ser_o | output | 1 | Serial result, least significant bit first |
| carry_o | output | 1 | Carry out of the most recent load |

## Verification
Every output comes from a register, so each result is due exactly one edge after the command that produces it. A load or clear at edge t shows up on `ser_o` and `carry_o` right after t. Bit k of a stream follows the k-th shift edge after the load. The bench changes its inputs on the falling edge and reads the outputs on the falling edge before the next rising edge. This way every check sees the state after exactly the number of edges it has counted. It expects bit k from the arithmetic sum of the operands, as `(a+b) >> k`.

// File: rtl/ssum_pkg.sv
package ssum_pkg;

  // Command applied to the registers at the next rising edge.
  typedef enum logic [1:0] {
    CMD_SHIFT = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_CLEAR = 2'd2
  } ssum_cmd_e;

  // Clear outranks load, and load outranks shift.
  function automatic ssum_cmd_e pick_cmd(input logic clr, input logic load);
    if (clr)       return CMD_CLEAR;
    else if (load) return CMD_LOAD;
    else           return CMD_SHIFT;
  endfunction

  // One-bit full adder: the sum bit.
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  // One-bit full adder: the carry bit.
  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a ^ b));
  endfunction

endpackage

// File: rtl/ssum_adder.sv
module ssum_adder
  import ssum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  // Ripple chain: one full-adder stage per bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sum_o[i]   = fa_sum(a_i[i], b_i[i], chain[i]);
    assign chain[i+1] = fa_carry(a_i[i], b_i[i], chain[i]);
  end

  assign cout_o = chain[WIDTH];

endmodule

// File: rtl/ssum_shreg.sv
module ssum_shreg
  import ssum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  ssum_cmd_e        cmd_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] data_o,
  output logic             ser_o
);

  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] data_d;

  always_comb begin
    unique case (cmd_i)
      CMD_CLEAR: data_d = '0;
      CMD_LOAD:  data_d = par_i;
      default:   data_d = {1'b0, data_q[WIDTH-1:1]};
    endcase
  end

  always_ff @(posedge clk_i) begin
    data_q <= data_d;
  end

  assign data_o = data_q;
  assign ser_o  = data_q[0];

  // Zero fill at the top end on every shift.
  AST_TOP_ZERO_FILL: assert property (@(posedge clk_i)
    (cmd_i == CMD_SHIFT) |=> (data_q[WIDTH-1] == 1'b0)); // R6

endmodule

// File: rtl/ssum_carry_reg.sv
module ssum_carry_reg
  import ssum_pkg::*;
(
  input  logic      clk_i,
  input  ssum_cmd_e cmd_i,
  input  logic      cin_i,
  output logic      carry_o
);

  logic carry_q;

  always_ff @(posedge clk_i) begin
    case (cmd_i)
      CMD_CLEAR: carry_q <= 1'b0;
      CMD_LOAD:  carry_q <= cin_i;
      default:   carry_q <= carry_q;
    endcase
  end

  assign carry_o = carry_q;

  AST_CARRY_HOLD: assert property (@(posedge clk_i)
    (cmd_i == CMD_SHIFT) |=> $stable(carry_q)); // R4

endmodule

// File: rtl/ssum_serializer.sv
module ssum_serializer
  import ssum_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             ser_o,
  output logic             carry_o
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

  ssum_cmd_e        cmd;
  logic             ev_clear;
  logic             ev_load;
  logic             ev_shift;
  logic [WIDTH-1:0] sum_w;
  logic             cout_w;
  logic [WIDTH-1:0] data_w;

  assign cmd      = pick_cmd(clr_i, load_i);
  assign ev_clear = (cmd == CMD_CLEAR);
  assign ev_load  = (cmd == CMD_LOAD);
  assign ev_shift = (cmd == CMD_SHIFT);

  ssum_adder #(.WIDTH(WIDTH)) u_add (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sum_o  (sum_w),
    .cout_o (cout_w)
  );

  ssum_shreg #(.WIDTH(WIDTH)) u_shr (
    .clk_i  (clk_i),
    .cmd_i  (cmd),
    .par_i  (sum_w),
    .data_o (data_w),
    .ser_o  (ser_o)
  );

  ssum_carry_reg u_cry (
    .clk_i   (clk_i),
    .cmd_i   (cmd),
    .cin_i   (cout_w),
    .carry_o (carry_o)
  );

  // Shifts since the last load, saturating at WIDTH. Used only by the checks.
  logic [CNT_W-1:0] shifts_seen;
  always_ff @(posedge clk_i) begin
    if (ev_clear || ev_load) shifts_seen <= ev_clear ? CNT_FULL : '0;
    else if (shifts_seen != CNT_FULL) shifts_seen <= shifts_seen + 1'b1;
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i)
    ev_clear |=> (ser_o == 1'b0 && carry_o == 1'b0 && data_w == '0)); // R1

  AST_CLEAR_BEATS_LOAD: assert property (@(posedge clk_i)
    (clr_i && load_i) |=> (data_w == '0)); // R2

  AST_LOAD_TAKES_SUM: assert property (@(posedge clk_i) disable iff (clr_i)
    ev_load |=> (data_w == $past(sum_w))); // R3

  AST_LOAD_TAKES_CARRY: assert property (@(posedge clk_i) disable iff (clr_i)
    ev_load |=> (carry_o == $past(cout_w))); // R4

  AST_SHIFT_ONE_PLACE: assert property (@(posedge clk_i) disable iff (clr_i)
    ev_shift |=> (data_w == ($past(data_w) >> 1))); // R5

  AST_DRAINED_LOW: assert property (@(posedge clk_i) disable iff (clr_i)
    (shifts_seen == CNT_FULL) |-> (ser_o == 1'b0)); // R6

endmodule

// File: tb/ssum_serializer_test.sv
module ssum_serializer_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         ser;
  logic         carry;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ssum_serializer #(.WIDTH(W)) uut (
    .clk_i   (clk),
    .clr_i   (clr),
    .load_i  (load),
    .opa_i   (opa),
    .opb_i   (opb),
    .ser_o   (ser),
    .carry_o (carry)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One rising edge, then stop on the falling edge where outputs are stable.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(input int a, input int b);
    opa = W'(a); opb = W'(b); load = 1'b1; clr = 1'b0;
    step();
    load = 1'b0;
  endtask

  initial begin
    int s;
    @(negedge clk);
    step();
    // R1: state after clear
    chk("R1 ser", ser, 1'b0);
    chk("R1 carry", carry, 1'b0);
    clr = 1'b0;

    // Exhaustive sweep: R3, R4, R5, R6
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        s = a + b;
        do_load(a, b);
        chk("R3", ser, 1'(s & 1));
        chk("R4 load", carry, 1'((s >> W) & 1));
        for (int k = 1; k < W; k++) begin
          step();
          chk("R5", ser, 1'((s >> k) & 1));
          chk("R4 hold", carry, 1'((s >> W) & 1));
        end
        step();
        chk("R6", ser, 1'b0);
        step();
        chk("R6", ser, 1'b0);
      end
    end

    // R2: clear and load together, operands with a carry
    opa = '1; opb = '1; clr = 1'b1; load = 1'b1;
    step();
    chk("R2 ser", ser, 1'b0);
    chk("R2 carry", carry, 1'b0);
    clr = 1'b0; load = 1'b0;
    for (int k = 0; k < W; k++) begin
      step();
      chk("R2 drained", ser, 1'b0);
    end

    // R7: reload halfway through a stream
    do_load(15, 0);
    step();
    s = 5 + 6;
    do_load(5, 6);
    chk("R7", ser, 1'(s & 1));
    for (int k = 1; k < W; k++) begin
      step();
      chk("R7", ser, 1'((s >> k) & 1));
    end
    step();
    chk("R7 tail", ser, 1'b0);

    // R8: clear halfway through a stream
    do_load(15, 15);
    step();
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R8 carry", carry, 1'b0);
    for (int k = 0; k < W; k++) begin
      chk("R8 ser", ser, 1'b0);
      step();
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule